// File: doc/BRIEF.md
# Row-Based Configuration Command Port

This block sits between a host bus and a device whose configuration is held in a small set of internal memory rows. The host selects between two byte-wide registers. Writes to the command register start an operation. Data bytes move through the data register. The block can clear the whole device, take in a complete configuration stream, clear one row, load one row, copy one row back out, or hand out a fixed four-byte device identifier.

Incoming row bytes collect in an internal shift register. A trailing check byte closes each row, and that byte must equal the XOR of the row's data bytes. A row that passes is committed to the addressed memory row. A row that fails raises a sticky error flag. That flag blocks every later data-register write until the host issues a device reset or a new full-load command. A configuration stream opens with the four identifier bytes, which are compared against the device's own identifier.

Every internal row operation keeps `busy` high for a fixed number of cycles. While `busy` is high the block ignores all host writes and reads. The host can poll for this through a status byte, or it can watch the `busy` pin directly.

Top module: `cfg_cmd_port`

## Requirements
- R1: After reset, `busy` is 0, the status byte is 0x00, and every memory row reads back as all-zero bytes.
- R2: Only `host_wdata[3:0]` of a command write selects the operation, and bits 7:4 are ignored. Code 0 and codes 7 to 15 change nothing.
- R3: Command code 1 clears every memory row, both error flags and the lockout. It raises `busy` for BUSY_CYCLES cycles, starting in the cycle after the write.
- R4: Command code 2 clears the error flags and the lockout, then expects the identifier bytes 0x13, 0x85, 0x02, 0xB7 followed by rows 0 to ROWS-1 in order. Each row is ROW_BYTES data bytes plus one check byte. A wrong identifier byte sets status bit 0 and locks out data writes.
- R5: Outside the identifier and row read-back modes, and whenever `host_sel` is 1 or `busy` is high, `host_rdata` shows the status byte. Bit 0 is the identifier error, bit 1 is the row check error, bit 2 is `busy`, and bits 7:3 are 0.
- R6: A check byte equal to the XOR of the row's data bytes commits the row to the addressed memory row. `busy` then goes high for BUSY_CYCLES cycles, starting in the cycle after the check byte.
- R7: A check byte that does not match sets status bit 1 and leaves the row unwritten. Every data-register write after that is ignored until a code 1 or code 2 command.
- R8: Command code 3 takes the next data byte as a row address (its low log2(ROWS) bits). It clears that row and holds `busy` for BUSY_CYCLES cycles.
- R9: Command code 4 takes the next data byte as a row address, followed by ROW_BYTES data bytes and a check byte. It commits that row under the rules of R6 and R7.
- R10: Command code 5 takes the next data byte as a row address and holds `busy` for BUSY_CYCLES cycles while it copies the row. The next ROW_BYTES data reads then return the row's bytes in the order they were written, with no check byte. After that, reads return the status byte.
- R11: Command code 6 makes the next four data reads return 0x13, 0x85, 0x02 and 0xB7, in that order. Reads after those four return the status byte.
- R12: Host writes and reads made while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe; the data register advances on this edge |
| host_sel | input | 1 | 1 selects the command register, 0 selects the data register |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Byte a read returns in this cycle (status or read-back data) |
| busy | output | 1 | High while an internal row operation is in progress |

## Verification
The embedded properties check, on every cycle, that writes and reads during `busy` leave the command state untouched, that a locked port ignores data writes, and that a bad check byte or a bad identifier byte raises its flag and the lockout in the next cycle. They also check that every commit raises `busy` and that the data register reflects status while a stream is loading. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. This covers whether the committed contents are right and come back in written order, the exact length of each `busy` window, what is left in memory after a rejected row, the decoding of the address and the command codes, and recovery from a lockout through reset or a fresh load.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DEV_RST  = 4'd1,
    CMD_LOAD_CFG = 4'd2,
    CMD_RST_ROW  = 4'd3,
    CMD_LOAD_ROW = 4'd4,
    CMD_READ_ROW = 4'd5,
    CMD_READ_ID  = 4'd6
  } cmd_e;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_HDR,
    MD_CROW,
    MD_ADDR,
    MD_LROW,
    MD_RROW,
    MD_RID
  } mode_e;

  localparam logic [31:0] DEVICE_ID = 32'h138502B7;

  localparam int ST_ID_ERR  = 0;
  localparam int ST_ROW_ERR = 1;
  localparam int ST_BUSY    = 2;

  // Byte n of the identifier, most significant byte first.
  function automatic logic [7:0] id_byte(input logic [1:0] n);
    return DEVICE_ID[31 - 8*n -: 8];
  endfunction

  function automatic logic [7:0] pack_status(input logic id_err, input logic row_err,
                                             input logic bsy);
    logic [7:0] s;
    s = 8'h00;
    s[ST_ID_ERR]  = id_err;
    s[ST_ROW_ERR] = row_err;
    s[ST_BUSY]    = bsy;
    return s;
  endfunction

endpackage

// File: rtl/cfg_busy_timer.sv
module cfg_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

endmodule

// File: rtl/cfg_row_mem.sv
module cfg_row_mem #(
  parameter int ROWS  = 8,
  parameter int ROW_W = 64,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic             clr_row_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [ROW_W-1:0] wdata_i,
  output logic [ROW_W-1:0] rdata_o
);
  logic [ROW_W-1:0] row_q [ROWS];
  logic [ROWS-1:0]  hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_dec
    assign hit[r] = (addr_i == AW'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) row_q[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (clr_all_i || (clr_row_i && hit[r])) row_q[r] <= '0;
        else if (wr_i && hit[r])                row_q[r] <= wdata_i;
      end
    end
  end

  assign rdata_o = row_q[addr_i];

endmodule

// File: rtl/cfg_cmd_port.sv
module cfg_cmd_port
  import cfg_port_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int ROW_BYTES   = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       busy
);
  localparam int AW = $clog2(ROWS);
  localparam int RW = ROW_BYTES * 8;
  localparam int SW = $clog2(ROW_BYTES);
  localparam int IW = $clog2(ROW_BYTES + 5);

  // XOR of all data bytes in a row.
  function automatic logic [7:0] ecb_fold(input logic [ROW_BYTES-1:0][7:0] b);
    logic [7:0] x;
    x = 8'h00;
    for (int k = 0; k < ROW_BYTES; k++) x ^= b[k];
    return x;
  endfunction

  mode_e                     mode_q;
  cmd_e                      op_q;
  logic [IW-1:0]             idx_q;
  logic [IW-1:0]             bcnt_q;
  logic [AW-1:0]             row_q;
  logic [ROW_BYTES-1:0][7:0] shreg_q;
  logic                      id_err_q, row_err_q, lock_q;

  // Named internal events
  logic        fn_wr, dat_wr, dat_rd;
  logic        ecb_ev, ecb_ok, commit_ev, ecb_bad_ev, hdr_bad_ev;
  logic        dev_rst_ev, clr_row_ev, copy_ev, timer_start;
  logic [3:0]  code;
  logic [7:0]  status_w;
  logic [AW-1:0] mem_addr;
  logic [RW-1:0] mem_rd;
  logic [SW-1:0] bsel, ridx;

  assign code   = host_wdata[3:0];
  assign fn_wr  = host_wr &  host_sel & ~busy;
  assign dat_wr = host_wr & ~host_sel & ~busy & ~lock_q;
  assign dat_rd = host_rd & ~host_sel & ~busy;
  assign bsel   = bcnt_q[SW-1:0];
  assign ridx   = idx_q[SW-1:0];

  assign ecb_ev     = dat_wr && (mode_q == MD_CROW || mode_q == MD_LROW)
                      && (bcnt_q == IW'(ROW_BYTES));
  assign ecb_ok     = ecb_ev && (host_wdata == ecb_fold(shreg_q));
  assign commit_ev  = ecb_ok;
  assign ecb_bad_ev = ecb_ev && !ecb_ok;
  assign hdr_bad_ev = dat_wr && (mode_q == MD_HDR) && (host_wdata != id_byte(idx_q[1:0]));
  assign dev_rst_ev = fn_wr && (code == CMD_DEV_RST);
  assign clr_row_ev = dat_wr && (mode_q == MD_ADDR) && (op_q == CMD_RST_ROW);
  assign copy_ev    = dat_wr && (mode_q == MD_ADDR) && (op_q == CMD_READ_ROW);
  assign timer_start = dev_rst_ev | commit_ev | clr_row_ev | copy_ev;

  assign mem_addr = (mode_q == MD_ADDR) ? host_wdata[AW-1:0] : row_q;
  assign status_w = pack_status(id_err_q, row_err_q, busy);

  cfg_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(timer_start), .busy_o(busy)
  );

  cfg_row_mem #(.ROWS(ROWS), .ROW_W(RW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .clr_all_i(dev_rst_ev), .clr_row_i(clr_row_ev), .wr_i(commit_ev),
    .addr_i(mem_addr), .wdata_i(shreg_q), .rdata_o(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_IDLE;
      op_q      <= CMD_NOP;
      idx_q     <= '0;
      bcnt_q    <= '0;
      row_q     <= '0;
      shreg_q   <= '0;
      id_err_q  <= 1'b0;
      row_err_q <= 1'b0;
      lock_q    <= 1'b0;
    end else if (fn_wr) begin
      case (code)
        CMD_DEV_RST: begin
          mode_q <= MD_IDLE; id_err_q <= 1'b0; row_err_q <= 1'b0; lock_q <= 1'b0;
        end
        CMD_LOAD_CFG: begin
          mode_q <= MD_HDR; idx_q <= '0; bcnt_q <= '0; row_q <= '0;
          id_err_q <= 1'b0; row_err_q <= 1'b0; lock_q <= 1'b0;
        end
        CMD_RST_ROW, CMD_LOAD_ROW, CMD_READ_ROW: begin
          mode_q <= MD_ADDR; op_q <= cmd_e'(code);
        end
        CMD_READ_ID: begin
          mode_q <= MD_RID; idx_q <= '0;
        end
        default: ;
      endcase
    end else if (dat_wr) begin
      case (mode_q)
        MD_HDR: begin
          if (hdr_bad_ev) begin id_err_q <= 1'b1; lock_q <= 1'b1; end
          if (idx_q == IW'(3)) begin
            mode_q <= MD_CROW; bcnt_q <= '0; row_q <= '0;
          end
          idx_q <= idx_q + 1'b1;
        end
        MD_CROW, MD_LROW: begin
          if (bcnt_q < IW'(ROW_BYTES)) begin
            shreg_q[bsel] <= host_wdata;
            bcnt_q <= bcnt_q + 1'b1;
          end else if (ecb_ok) begin
            bcnt_q <= '0;
            if (mode_q == MD_LROW || row_q == AW'(ROWS - 1)) mode_q <= MD_IDLE;
            else row_q <= row_q + 1'b1;
          end else begin
            row_err_q <= 1'b1; lock_q <= 1'b1;
          end
        end
        MD_ADDR: begin
          row_q <= host_wdata[AW-1:0]; bcnt_q <= '0; idx_q <= '0;
          case (op_q)
            CMD_LOAD_ROW: mode_q <= MD_LROW;
            CMD_READ_ROW: begin mode_q <= MD_RROW; shreg_q <= mem_rd; end
            default:      mode_q <= MD_IDLE;
          endcase
        end
        default: ;
      endcase
    end else if (dat_rd) begin
      if (mode_q == MD_RID) begin
        if (idx_q == IW'(3)) mode_q <= MD_IDLE;
        idx_q <= idx_q + 1'b1;
      end else if (mode_q == MD_RROW) begin
        if (idx_q == IW'(ROW_BYTES - 1)) mode_q <= MD_IDLE;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    host_rdata = status_w;
    if (!busy && !host_sel) begin
      if (mode_q == MD_RID)       host_rdata = id_byte(idx_q[1:0]);
      else if (mode_q == MD_RROW) host_rdata = shreg_q[ridx];
    end
  end

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (host_wr || host_rd)) |=> ($stable(mode_q) && $stable(idx_q) && $stable(bcnt_q)));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && host_wr && !host_sel) |=> ($stable(mode_q) && $stable(bcnt_q) && $stable(idx_q)));

  // R7
  ecb_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecb_bad_ev |=> (row_err_q && lock_q && !busy));

  // R4
  id_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad_ev |=> (id_err_q && lock_q));

  // R6
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> busy);

  // R5
  cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_HDR || mode_q == MD_CROW) |-> (host_rdata == status_w));

endmodule

// File: tb/sim_cfg_cmd_port.sv
`timescale 1ns/1ps
module sim_cfg_cmd_port;
  localparam int NR = 8;
  localparam int RB = 8;
  localparam int BC = 4;
  localparam int PH_IDLE = 0, PH_HDR = 1, PH_CROW = 2, PH_ADDR = 3, PH_LROW = 4;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic busy;

  cfg_cmd_port #(.ROWS(NR), .ROW_BYTES(RB), .BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  // Behavioural model
  byte unsigned id_bytes[4] = '{8'h13, 8'h85, 8'h02, 8'hB7};
  byte unsigned mm[NR][RB];
  byte unsigned exp_q[$];
  byte unsigned rowbuf[$];
  int m_busy = 0, m_ph = PH_IDLE, m_k = 0, m_row = 0, m_op = 0;
  bit m_iderr = 0, m_rowerr = 0, m_lock = 0;

  function automatic byte unsigned m_status();
    return {5'b0, (m_busy > 0), m_rowerr, m_iderr};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Every clock: compare busy and read data against the model
  always @(negedge clk) begin
    if (chk_on) begin
      byte unsigned e;
      e = m_status();
      if (!host_sel && m_busy == 0 && exp_q.size() > 0) e = exp_q[0];
      check({cur_req, " busy"}, {7'b0, busy}, {7'b0, (m_busy > 0)});
      check({cur_req, " rdata"}, host_rdata, e);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      finish_run();
    end
  end

  task automatic m_fn(input byte unsigned d);
    int c;
    c = d & 15;
    if (c >= 1 && c <= 6) begin exp_q.delete(); rowbuf.delete(); end
    case (c)
      1: begin
        foreach (mm[r, k]) mm[r][k] = 0;
        m_iderr = 0; m_rowerr = 0; m_lock = 0; m_ph = PH_IDLE; m_busy = BC;
      end
      2: begin m_iderr = 0; m_rowerr = 0; m_lock = 0; m_ph = PH_HDR; m_k = 0; end
      3, 4, 5: begin m_ph = PH_ADDR; m_op = c; end
      6: begin m_ph = PH_IDLE; foreach (id_bytes[i]) exp_q.push_back(id_bytes[i]); end
      default: ;
    endcase
  endtask

  task automatic m_data(input byte unsigned b);
    byte unsigned x;
    int a;
    if (m_lock) return;
    case (m_ph)
      PH_HDR: begin
        if (b != id_bytes[m_k]) begin m_iderr = 1; m_lock = 1; end
        m_k++;
        if (m_k == 4) begin m_ph = PH_CROW; m_row = 0; rowbuf.delete(); end
      end
      PH_CROW, PH_LROW: begin
        if (rowbuf.size() < RB) rowbuf.push_back(b);
        else begin
          x = 0;
          foreach (rowbuf[i]) x ^= rowbuf[i];
          if (x == b) begin
            foreach (rowbuf[i]) mm[m_row][i] = rowbuf[i];
            m_busy = BC;
            rowbuf.delete();
            if (m_ph == PH_LROW || m_row == NR - 1) m_ph = PH_IDLE;
            else m_row++;
          end else begin m_rowerr = 1; m_lock = 1; end
        end
      end
      PH_ADDR: begin
        a = b % NR;
        rowbuf.delete();
        if (m_op == 3) begin
          for (int k = 0; k < RB; k++) mm[a][k] = 0;
          m_busy = BC; m_ph = PH_IDLE;
        end else if (m_op == 4) begin m_row = a; m_ph = PH_LROW; end
        else begin
          for (int k = 0; k < RB; k++) exp_q.push_back(mm[a][k]);
          m_busy = BC; m_ph = PH_IDLE;
        end
      end
      default: ;
    endcase
  endtask

  // One bus cycle; inputs change 1 ns after the rising edge
  task automatic access(input bit sel, input bit wr, input bit rd, input byte unsigned d);
    bit was_busy;
    host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
    @(posedge clk);
    was_busy = (m_busy > 0);
    if (m_busy > 0) m_busy--;
    #1;
    host_wr = 0; host_rd = 0; host_sel = 0;
    if (!was_busy) begin
      if (wr && sel) m_fn(d);
      else if (wr) m_data(d);
      else if (rd && exp_q.size() > 0) void'(exp_q.pop_front());
    end
  endtask

  task automatic idle(); access(0, 0, 0, 0); endtask
  task automatic fn(input byte unsigned d); access(1, 1, 0, d); endtask
  task automatic wd(input byte unsigned d); access(0, 1, 0, d); endtask
  task automatic rd(); access(0, 0, 1, 0); endtask
  task automatic wait_free(); while (m_busy > 0) idle(); endtask

  function automatic byte unsigned pat(input int r, input int k, input int s);
    return byte'((r * 37 + k * 11 + s) & 255);
  endfunction

  task automatic send_row(input int r, input int s, input bit bad);
    byte unsigned x;
    x = 0;
    for (int k = 0; k < RB; k++) begin wd(pat(r, k, s)); x ^= pat(r, k, s); end
    wd(bad ? byte'(x ^ 8'h01) : x);
  endtask

  task automatic read_row(input byte unsigned a);
    fn(8'h05); wd(a); wait_free();
    for (int k = 0; k < RB + 1; k++) rd();
  endtask

  initial begin
    foreach (mm[r, k]) mm[r][k] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 busy", {7'b0, busy}, 8'h00);
    check("R1 status", host_rdata, 8'h00);
    rst_n = 1;
    chk_on = 1;
    idle();
    cur_req = "R1"; read_row(8'd0);

    cur_req = "R11"; fn(8'h06);
    for (int i = 0; i < 5; i++) rd();

    cur_req = "R4"; fn(8'h02);
    for (int i = 0; i < 4; i++) wd(id_bytes[i]);
    for (int r = 0; r < NR; r++) begin
      cur_req = "R6"; send_row(r, 5, 0); wait_free();
    end
    cur_req = "R10"; read_row(8'd3);
    read_row(8'd7);

    // R12: writes and reads during busy are dropped
    cur_req = "R12"; fn(8'h04); wd(8'd1); send_row(1, 9, 0);
    wd(8'hAA); fn(8'h06); rd(); wait_free(); rd();
    cur_req = "R9"; read_row(8'd1);

    cur_req = "R8"; fn(8'h03); wd(8'hF3); wait_free(); read_row(8'd3);

    cur_req = "R9"; fn(8'h04); wd(8'd5); send_row(5, 77, 0); wait_free(); read_row(8'd5);

    cur_req = "R7"; fn(8'h04); wd(8'd2); send_row(2, 200, 1);
    wd(8'h55); wd(8'h00); idle();
    fn(8'h03); wd(8'd4); idle();
    read_row(8'd2); read_row(8'd4);

    cur_req = "R2"; fn(8'hF0); idle(); fn(8'h07); fn(8'h1F); idle();
    fn(8'h36); for (int i = 0; i < 4; i++) rd();

    cur_req = "R4"; fn(8'h02); wd(8'h13); wd(8'h86); wd(8'h02); wd(8'hB7);
    send_row(0, 3, 0); idle();
    read_row(8'd0);

    cur_req = "R3"; fn(8'h01); for (int i = 0; i < BC + 1; i++) idle();
    read_row(8'd5); read_row(8'd0);

    cur_req = "R5"; access(1, 0, 1, 0); fn(8'h02); wd(8'h13); rd(); idle();
    fn(8'h01); wait_free(); idle();

    chk_on = 0;
    finish_run();
  end
endmodule